// File: doc/BRIEF.md
# Configurable Serial Transceiver with Control Register

This block pairs an asynchronous serial transmitter with a matching receiver. One 8-bit control register, written and read through a simple register port, sets how both halves behave. The transmitter takes bytes over a valid/ready handshake and shifts them out on `txd`. The receiver rebuilds bytes from `rxd` and presents each one with a single-cycle strobe and a parity-error flag.

The register controls several behaviours. Either side can be switched on or off. The transmitter can be made to wait for an active-low clear-to-send input. A parity bit can be added in even or odd sense, and the transmitter can send one or two stop bits. A break can force the line low. A loopback mode feeds the outgoing stream straight into the receiver and holds the pin idle.

A frame is one low start bit, then eight data bits with the least significant first, then the optional parity bit, then the stop bits, which are high. The line idles high. One bit lasts 16 baud ticks. A baud tick occurs once every `CLK_DIV` clock cycles.

Top module: `serial_port_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `txd` is high, `tx_ready` is low and `rx_valid` is low.
- R2: A register write takes effect on the next clock edge, and `reg_rdata` then returns the written byte. Bit assignments: 7 transmit enable, 6 receive enable, 5 CTS gating, 4 parity enable, 3 odd parity, 2 break, 1 two stop bits, 0 loopback.
- R3: The transmitter sends a low start bit and then the eight data bits least significant first. Each bit lasts 16 baud ticks, and the line is high when no frame is being sent.
- R4: When parity is enabled, one parity bit follows the data. With bit 3 at 0 the parity bit equals the XOR of the data bits (even parity). With bit 3 at 1 it is the inverse of that XOR (odd parity).
- R5: Bit 1 at 0 gives one high stop bit per frame and bit 1 at 1 gives two. The next frame never starts before the last stop bit has ended, even when bytes are sent back to back.
- R6: `tx_ready` is high only when transmit enable is set, no frame is in flight, and either CTS gating is off or `cts_n` is low. While CTS gating is off, the level of `cts_n` has no effect.
- R7: If `cts_n` goes high in the middle of a frame, that frame still completes intact. No further frame starts until `cts_n` is low again.
- R8: While break is set, `txd` is 0 from the cycle after the write onward, including in the middle of a frame.
- R9: While loopback is set, `txd` stays high and every transmitted frame is received internally with its data intact.
- R10: With receive enable set, a well-formed frame on `rxd` produces one `rx_valid` pulse carrying the byte on `rx_data`. With receive enable clear, no `rx_valid` pulse is produced.
- R11: A low pulse on `rxd` that has ended before the middle of the start bit is treated as noise and produces no byte.
- R12: When parity is enabled and the received parity bit does not match the selected sense, `rx_perr` is high in the same cycle as `rx_valid`. Otherwise `rx_perr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter accepts a byte this cycle |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_perr | output | 1 | Parity mismatch on the byte being strobed |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| cts_n | input | 1 | Active-low clear-to-send |

## Verification
A corrupted transmit shift register or bit counter shows up on the very next frame: a sampled data bit, parity bit or stop bit on `txd` comes out wrong, or the following start bit arrives too early. A stuck receiver state appears as a missing or duplicated `rx_valid` pulse, or a wrong `rx_data`, within about one frame time (at most 12 bit periods). Gating faults show up within a cycle as `tx_ready` disagreeing with the enable and `cts_n` levels. A broken break path shows up as a high `txd` on the cycle after break is written.

// File: rtl/serial_port_ctl.sv
module serial_port_ctl #(
  parameter int CLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_perr,
  output logic       txd,
  input  logic       rxd,
  input  logic       cts_n
);

  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_MAX = 12;

  logic [DW-1:0] div_q;
  logic          tick;
  assign tick = (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + DW'(1);

  logic [7:0] ctl;
  logic t_en, r_en, cts_en, par_en, par_odd, brk, two_stop, loop;
  assign {t_en, r_en, cts_en, par_en, par_odd, brk, two_stop, loop} = ctl;
  assign reg_rdata = ctl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (reg_we) ctl <= reg_wdata;

  // transmitter
  logic                 tx_busy;
  logic [FRAME_MAX-1:0] tx_sh;
  logic [3:0]           tx_left, tx_os, frame_len;
  logic                 tx_go, tx_fire, tx_par, tx_line, tx_ser;
  logic [FRAME_MAX-1:0] frame_w;

  assign tx_go     = t_en & (~cts_en | ~cts_n);
  assign tx_ready  = ~tx_busy & tx_go;
  assign tx_fire   = tx_valid & tx_ready;
  assign tx_par    = (^tx_data) ^ par_odd;
  assign frame_w   = par_en ? {2'b11, tx_par, tx_data, 1'b0} : {3'b111, tx_data, 1'b0};
  assign frame_len = 4'd10 + {3'd0, par_en} + {3'd0, two_stop};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_os   <= '0;
    end else if (tx_fire) begin
      tx_busy <= 1'b1;
      tx_sh   <= frame_w;
      tx_left <= frame_len;
      tx_os   <= '0;
    end else if (tx_busy && tick) begin
      if (tx_os == 4'd15) begin
        tx_os   <= '0;
        tx_sh   <= {1'b1, tx_sh[FRAME_MAX-1:1]};
        tx_left <= tx_left - 4'd1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end else begin
        tx_os <= tx_os + 4'd1;
      end
    end

  assign tx_line = tx_busy ? tx_sh[0] : 1'b1;
  assign tx_ser  = tx_line & ~brk;
  assign txd     = loop | tx_ser;

  // receiver
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_t;
  rx_st_t     rx_st;
  logic       rx_s1, rx_bit, rx_armed, rx_pbit;
  logic [3:0] rx_os;
  logic [2:0] rx_cnt;
  logic [7:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1  <= 1'b1;
      rx_bit <= 1'b1;
    end else begin
      rx_s1  <= loop ? tx_ser : rxd;
      rx_bit <= rx_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st    <= RX_IDLE;
      rx_armed <= 1'b0;
      rx_os    <= '0;
      rx_cnt   <= '0;
      rx_sh    <= '0;
      rx_pbit  <= 1'b0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      if (!r_en) begin
        rx_st    <= RX_IDLE;
        rx_armed <= 1'b0;
      end else if (tick) begin
        case (rx_st)
          RX_IDLE:
            if (rx_bit) rx_armed <= 1'b1;
            else if (rx_armed) begin
              rx_st    <= RX_START;
              rx_os    <= '0;
              rx_armed <= 1'b0;
            end
          RX_START:
            if (rx_os == 4'd7) begin
              rx_os  <= '0;
              rx_cnt <= '0;
              rx_st  <= rx_bit ? RX_IDLE : RX_DATA;
            end else rx_os <= rx_os + 4'd1;
          RX_DATA:
            if (rx_os == 4'd15) begin
              rx_os  <= '0;
              rx_sh  <= {rx_bit, rx_sh[7:1]};
              rx_cnt <= rx_cnt + 3'd1;
              if (rx_cnt == 3'd7) rx_st <= par_en ? RX_PAR : RX_STOP;
            end else rx_os <= rx_os + 4'd1;
          RX_PAR:
            if (rx_os == 4'd15) begin
              rx_os   <= '0;
              rx_pbit <= rx_bit;
              rx_st   <= RX_STOP;
            end else rx_os <= rx_os + 4'd1;
          RX_STOP:
            if (rx_os == 4'd15) begin
              rx_os    <= '0;
              rx_st    <= RX_IDLE;
              rx_valid <= 1'b1;
              rx_perr  <= par_en & ((^{rx_sh, rx_pbit}) ^ par_odd);
            end else rx_os <= rx_os + 4'd1;
          default: rx_st <= RX_IDLE;
        endcase
      end
    end

  assign rx_data = rx_sh;

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata == $past(reg_wdata));
  // R3
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R10
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_en |=> !rx_valid);
  // R12
  perr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_perr |-> rx_valid);
  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_go) |=> !tx_ready);

endmodule

// File: tb/serial_port_ctl_bench.sv
module serial_port_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 1;
  localparam int BIT = 16 * DIV;
  localparam logic [7:0] C_TEN = 8'h80, C_REN = 8'h40, C_CTS = 8'h20, C_PAR = 8'h10,
                         C_ODD = 8'h08, C_BRK = 8'h04, C_TWO = 8'h02, C_LOOP = 8'h01;

  logic clk = 0, rst_n = 0, reg_we = 0, tx_valid = 0, rxd = 1, cts_n = 1;
  logic [7:0] reg_wdata = 0, tx_data = 0, reg_rdata, rx_data;
  logic tx_ready, rx_valid, rx_perr, txd;
  int checks = 0, errors = 0, low_seen = 0;
  bit mon_low = 0;
  logic [7:0] rq_d[$];
  bit rq_p[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_port_ctl #(.CLK_DIV(DIV)) u_serial_port_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_perr(rx_perr), .txd(txd), .rxd(rxd), .cts_n(cts_n));

  always @(negedge clk) begin
    if (rx_valid) begin rq_d.push_back(rx_data); rq_p.push_back(rx_perr); end
    if (mon_low && !txd) low_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); tx_valid = 1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 0;
  endtask

  function automatic bit pbit(input logic [7:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  task automatic cap(input logic [7:0] exp, input bit pe, input bit po, input int ns);
    logic [7:0] got;
    int n = 0;
    @(negedge clk);
    while (txd && n < 40 * BIT) begin @(negedge clk); n++; end
    repeat (BIT/2) @(negedge clk);
    chk(txd == 0, "R3 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); got[i] = txd; end
    chk(got == exp, "R3 data bits", got, exp);
    if (pe) begin
      repeat (BIT) @(negedge clk);
      chk(txd == pbit(exp, po), "R4 parity bit", txd, pbit(exp, po));
    end
    for (int s = 0; s < ns; s++) begin
      repeat (BIT) @(negedge clk);
      chk(txd == 1, "R5 stop bit", txd, 1);
    end
  endtask

  task automatic wait_rx();
    int n = 0;
    while (rq_d.size() == 0 && n < 30 * BIT) begin @(negedge clk); n++; end
  endtask

  task automatic drive(input logic [7:0] d, input bit pe, input bit po, input bit bad);
    @(negedge clk);
    rxd = 0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BIT) @(negedge clk); end
    if (pe) begin rxd = pbit(d, po) ^ bad; repeat (BIT) @(negedge clk); end
    rxd = 1; repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic rx_expect(input logic [7:0] d, input bit p, input string req);
    wait_rx();
    chk(rq_d.size() == 1, req, rq_d.size(), 1);
    if (rq_d.size() > 0) begin
      chk(rq_d[0] == d, req, rq_d[0], d);
      chk(rq_p[0] == p, "R12 parity flag", rq_p[0], p);
    end
    rq_d.delete(); rq_p.delete();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int cfg;
    logic [7:0] b, c;
    int lows, rdy;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(reg_rdata == 8'h00, "R1 register reset", reg_rdata, 0);
    chk(txd == 1, "R1 txd idle", txd, 1);
    chk(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
    chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);

    // R2 full sweep of register values
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      chk(reg_rdata == 8'(v), "R2 readback", reg_rdata, v);
    end
    wr(8'h00);

    // R3 R4 R5: six framing configurations, back-to-back pairs
    for (int k = 0; k < 6; k++) begin
      bit pe, po, two;
      pe = (k >= 2); po = (k >= 4); two = k[0];
      wr(C_TEN | (pe ? C_PAR : 8'h0) | (po ? C_ODD : 8'h0) | (two ? C_TWO : 8'h0));
      for (int j = 0; j < 4; j++) begin
        b = 8'(j * 83 + k * 29 + 1); c = ~b ^ 8'(j);
        fork
          begin send(b); send(c); end
          begin cap(b, pe, po, two ? 2 : 1); cap(c, pe, po, two ? 2 : 1); end
        join
      end
      repeat (3 * BIT) @(negedge clk);
    end

    // R9: loopback, exhaustive byte sweep with even parity and two stops
    wr(C_TEN | C_REN | C_LOOP | C_PAR | C_TWO);
    repeat (4 * BIT) @(negedge clk);
    rq_d.delete(); rq_p.delete();
    low_seen = 0; mon_low = 1;
    for (int v = 0; v < 256; v++) begin
      send(8'(v));
      rx_expect(8'(v), 0, "R9 loopback data");
    end
    // R9 other configurations
    for (int k = 0; k < 3; k++) begin
      cfg = (k == 0) ? 0 : (k == 1) ? (C_PAR | C_ODD) : C_TWO;
      wr(C_TEN | C_REN | C_LOOP | 8'(cfg));
      for (int j = 0; j < 16; j++) begin
        send(8'(j * 17 + k));
        rx_expect(8'(j * 17 + k), 0, "R9 loopback data");
      end
    end
    mon_low = 0;
    chk(low_seen == 0, "R9 txd held high", low_seen, 0);

    // R10 R12: external receive
    wr(C_REN | C_PAR);
    repeat (4 * BIT) @(negedge clk);
    rq_d.delete(); rq_p.delete();
    for (int j = 0; j < 8; j++) begin
      b = 8'(j * 37 + 5);
      drive(b, 1, 0, j[0]);
      rx_expect(b, j[0], "R10 rx even");
    end
    wr(C_REN | C_PAR | C_ODD);
    for (int j = 0; j < 8; j++) begin
      b = 8'(j * 53 + 2);
      drive(b, 1, 1, j[1]);
      rx_expect(b, j[1], "R10 rx odd");
    end
    wr(C_REN);
    drive(8'hC3, 0, 0, 0);
    rx_expect(8'hC3, 0, "R10 rx no parity");
    wr(8'h00);
    drive(8'h5A, 0, 0, 0);
    repeat (2 * BIT) @(negedge clk);
    chk(rq_d.size() == 0, "R10 receiver disabled", rq_d.size(), 0);

    // R11 noise pulse
    wr(C_REN);
    repeat (2 * BIT) @(negedge clk);
    rq_d.delete(); rq_p.delete();
    @(negedge clk); rxd = 0; repeat (5) @(negedge clk); rxd = 1;
    repeat (12 * BIT) @(negedge clk);
    chk(rq_d.size() == 0, "R11 glitch rejected", rq_d.size(), 0);
    drive(8'h96, 0, 0, 0);
    rx_expect(8'h96, 0, "R11 frame after glitch");

    // R6 CTS gating
    wr(C_TEN | C_CTS);
    cts_n = 1;
    @(negedge clk);
    chk(tx_ready == 0, "R6 blocked by cts", tx_ready, 0);
    tx_valid = 1; tx_data = 8'h11; lows = 0;
    repeat (2 * BIT) begin @(negedge clk); if (!txd) lows++; end
    tx_valid = 0;
    chk(lows == 0, "R6 no frame while blocked", lows, 0);
    wr(C_TEN);
    chk(tx_ready == 1, "R6 cts ignored when gating off", tx_ready, 1);
    wr(8'h00);
    chk(tx_ready == 0, "R6 transmit disabled", tx_ready, 0);
    wr(C_TEN | C_CTS);
    cts_n = 0;
    @(negedge clk);
    chk(tx_ready == 1, "R6 ready with cts low", tx_ready, 1);

    // R7 CTS drop mid frame
    fork
      send(8'h3C);
      cap(8'h3C, 0, 0, 1);
      begin repeat (3 * BIT) @(negedge clk); cts_n = 1; end
    join
    repeat (BIT) @(negedge clk);
    tx_valid = 1; tx_data = 8'hA6; lows = 0; rdy = 0;
    repeat (3 * BIT) begin @(negedge clk); if (!txd) lows++; if (tx_ready) rdy++; end
    chk(lows == 0, "R7 waits after frame", lows, 0);
    chk(rdy == 0, "R7 ready held low", rdy, 0);
    cts_n = 0;
    fork
      send(8'hA6);
      cap(8'hA6, 0, 0, 1);
    join
    repeat (2 * BIT) @(negedge clk);

    // R8 break mid frame
    wr(C_TEN);
    fork
      send(8'hFF);
      begin
        repeat (2 * BIT) @(negedge clk);
        wr(C_TEN | C_BRK);
        chk(txd == 0, "R8 break immediate", txd, 0);
        lows = 0;
        repeat (12 * BIT) begin @(negedge clk); if (!txd) lows++; end
        chk(lows == 12 * BIT, "R8 break held", lows, 12 * BIT);
        wr(C_TEN);
        chk(txd == 1, "R8 break released", txd, 1);
      end
    join

    finish_run();
  end
endmodule